// File: doc/BRIEF.md
# Periodic Tick Timer with Acknowledging Read

This block produces the periodic interrupt an operating system uses as its scheduling tick. The system clock is divided by 16 by a prescaler, and each prescaler tick advances a 20-bit interval counter. When that counter has reached a programmable limit, the next tick returns it to zero. That wrap adds one to a 12-bit count of elapsed intervals and sets a pending flag, and the flag drives a level interrupt when interrupts are enabled.

Software sees four word registers through single-cycle read and write strobes. Two of them return the same packed snapshot of both counters. Reading one of them acknowledges the tick: it clears the elapsed-interval count and the pending flag. Reading the other has no side effect, so a profiler can sample time without losing a pending tick. The enable bit is applied only while the interval counter sits at zero. A disabled timer therefore finishes its current interval before it stops. A debug-halt input freezes all counting.

Top module: `os_tick_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and the timer is stopped.
- R2: While running and not halted, the interval counter changes only on every 16th clock, which is the prescaler tick.
- R3: On a tick the interval counter increments, unless it is already at or above the limit in mode bits [19:0]. In that case it returns to 0 and the elapsed-interval count increments. A limit of 0 wraps on every tick.
- R4: Every wrap sets the pending flag (status register, address 1, bit 0). `irq` is high exactly when that flag and the interrupt-enable bit (mode bit 25) are both 1.
- R5: Writing the mode register (address 0) changes the limit and the control bits. It does not change either counter or the prescaler phase.
- R6: A read of address 2 returns {elapsed count in [31:20], interval counter in [19:0]}. After that read the elapsed count is 0 and the pending flag is clear.
- R7: A read of address 3 returns the same packing as address 2 and changes neither counter nor the pending flag.
- R8: The running state follows the enable bit (mode bit 24) only on cycles where the interval counter is 0. After a disable, counting continues up to the wrap and then stops at 0. Starting again resets the prescaler, so the first tick comes 16 clocks later.
- R9: While `dbg_halt` is high, neither counter nor the prescaler moves.
- R10: When a wrap and an address-2 read fall in the same cycle, the elapsed count becomes 1 and the pending flag stays set.
- R11: The elapsed count stops at 4095 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe; side effects act at the clock edge |
| addr | input | 2 | Register select: 0 mode, 1 status, 2 acknowledging value, 3 image |
| wdata | input | 32 | Write data |
| dbg_halt | input | 1 | Freezes all counting while high |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Level interrupt |

## Verification
An acknowledging read can land on the same clock edge as a counter wrap. In that cycle the clear competes with the increment of the elapsed count and with the setting of the pending flag. The bench predicts, from its reference model, the cycle before a wrap and issues the address-2 read exactly there. It then checks that the count reads 1 and that the flag and interrupt remain asserted. Beyond that case, a disable request that arrives mid-interval and a halt that covers a tick are each compared cycle by cycle against the model.

// File: rtl/os_tick_pkg.sv
package os_tick_pkg;
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ACK  = 2'd2,
    SEL_IMG  = 2'd3
  } reg_sel_e;

  localparam int MODE_RUN_BIT = 24;
  localparam int MODE_IE_BIT  = 25;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic halt,
  input  logic restart,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase_q;
  logic         advance;

  assign advance = run && !halt;
  assign tick    = advance && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (advance) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  // R9
  presc_halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !restart) |=> $stable(phase_q));
  // R2
  presc_tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (phase_q == '0));
endmodule

// File: rtl/tick_interval.sv
module tick_interval #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap,
  output logic         at_zero
);
  function automatic logic limit_reached(input logic [W-1:0] c, input logic [W-1:0] lim);
    return c >= lim;
  endfunction

  logic [W-1:0] count_q;

  assign wrap    = tick && limit_reached(count_q, limit);
  assign at_zero = (count_q == '0);
  assign count   = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (wrap)  count_q <= '0;
    else if (tick)  count_q <= count_q + 1'b1;
  end

  // R3
  ival_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count_q == '0));
  // R2
  ival_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_q));
endmodule

// File: rtl/tick_wrap_count.sv
module tick_wrap_count #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic         ack,
  output logic [W-1:0] count,
  output logic         pending
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  logic [W-1:0] count_q;
  logic         pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      pend_q  <= 1'b0;
    end else if (wrap) begin
      count_q <= ack ? W'(1) : sat_inc(count_q);
      pend_q  <= 1'b1;
    end else if (ack) begin
      count_q <= '0;
      pend_q  <= 1'b0;
    end
  end

  assign count   = count_q;
  assign pending = pend_q;

  // R10
  wcnt_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ack) |=> (count_q == W'(1)) && pend_q);
  // R6
  wcnt_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap) |=> (count_q == '0) && !pend_q);
  // R11
  wcnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == TOP && !ack) |=> (count_q == TOP));
  // R4
  wcnt_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pend_q);
endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer
  import os_tick_pkg::*;
#(
  parameter int PRESC_DIV = 16,
  parameter int CNT_W     = 20,
  parameter int OVF_W     = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [1:0]             addr,
  input  logic [CNT_W+OVF_W-1:0] wdata,
  input  logic                   dbg_halt,
  output logic [CNT_W+OVF_W-1:0] rdata,
  output logic                   irq
);
  localparam int DW = CNT_W + OVF_W;

  logic [CNT_W-1:0] limit_q;
  logic             en_q, ie_q, run_q;
  logic [CNT_W-1:0] ival;
  logic [OVF_W-1:0] ovf;
  logic             tick, wrap, ival_zero, pending;
  logic             mode_wr, ack_rd, img_rd, start;

  assign mode_wr = wr_en && (reg_sel_e'(addr) == SEL_MODE);
  assign ack_rd  = rd_en && (reg_sel_e'(addr) == SEL_ACK);
  assign img_rd  = rd_en && (reg_sel_e'(addr) == SEL_IMG);
  assign start   = !run_q && en_q && ival_zero;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DW-1:MODE_IE_BIT+1], wdata[MODE_RUN_BIT-1:CNT_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
    end else if (mode_wr) begin
      limit_q <= wdata[CNT_W-1:0];
      en_q    <= wdata[MODE_RUN_BIT];
      ie_q    <= wdata[MODE_IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= 1'b0;
    else if (ival_zero) run_q <= en_q;
  end

  tick_prescaler #(.DIV(PRESC_DIV)) presc_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .halt(dbg_halt),
    .restart(start), .tick(tick)
  );

  tick_interval #(.W(CNT_W)) ival_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .limit(limit_q),
    .count(ival), .wrap(wrap), .at_zero(ival_zero)
  );

  tick_wrap_count #(.W(OVF_W)) wcnt_i (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack_rd),
    .count(ovf), .pending(pending)
  );

  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(addr))
      SEL_MODE: begin
        rdata[CNT_W-1:0]    = limit_q;
        rdata[MODE_RUN_BIT] = en_q;
        rdata[MODE_IE_BIT]  = ie_q;
      end
      SEL_STAT: rdata[0] = pending;
      default:  rdata = {ovf, ival};
    endcase
  end

  assign irq = pending && ie_q;

  // R7
  img_no_side_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (img_rd && !wrap) |=> $stable(ovf) && $stable(pending));
  // R8
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ival_zero |=> (run_q == $past(run_q)));
  // R5
  mode_write_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !tick) |=> $stable(ival));
  // R4
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q);
endmodule

// File: tb/os_tick_timer_tb_top.sv
module os_tick_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, dbg_halt = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_p = 0, m_c = 0, m_o = 0, m_piv = 0;
  bit m_f = 0, m_en = 0, m_ie = 0, m_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  os_tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .dbg_halt(dbg_halt), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) begin
    bit tk, wr, ack, st, run_n;
    if (!rst_n) begin
      m_p = 0; m_c = 0; m_o = 0; m_piv = 0;
      m_f = 0; m_en = 0; m_ie = 0; m_run = 0;
    end else begin
      tk    = m_run && !dbg_halt && (m_p == 15);
      wr    = tk && (m_c >= m_piv);
      ack   = rd_en && (addr == 2'd2);
      st    = !m_run && m_en && (m_c == 0);
      run_n = (m_c == 0) ? m_en : m_run;
      if (st) m_p = 0;
      else if (m_run && !dbg_halt) m_p = (m_p + 1) % 16;
      if (tk) m_c = wr ? 0 : m_c + 1;
      if (wr) begin
        m_o = ack ? 1 : ((m_o < 4095) ? m_o + 1 : 4095);
        m_f = 1;
      end else if (ack) begin
        m_o = 0;
        m_f = 0;
      end
      m_run = run_n;
      if (wr_en && addr == 2'd0) begin
        m_piv = int'(wdata[19:0]);
        m_en  = wdata[24];
        m_ie  = wdata[25];
      end
    end
  end

  function automatic logic [31:0] exp_rdata(input logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: begin v[19:0] = m_piv[19:0]; v[24] = m_en; v[25] = m_ie; end
      2'd1: v[0] = m_f;
      default: v = {m_o[11:0], m_c[19:0]};
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    check({cur_req, " rdata"}, rdata, exp_rdata(addr));
    check({cur_req, " irq"}, {31'd0, irq}, {31'd0, m_f && m_ie});
  endtask

  task automatic cyc(input logic w, input logic r, input logic [1:0] a,
                     input logic [31:0] d, input logic h);
    @(negedge clk);
    compare_model();
    wr_en = w; rd_en = r; addr = a; wdata = d; dbg_halt = h;
  endtask

  task automatic idle(input int n, input logic [1:0] a, input logic h);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, a, '0, h);
  endtask

  function automatic logic [31:0] mode_word(input int piv, input bit en, input bit ie);
    logic [31:0] v = '0;
    v[19:0] = piv[19:0]; v[24] = en; v[25] = ie;
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    bit hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every register
    for (int a = 0; a < 4; a++) begin
      addr = a[1:0];
      #1 check("R1 reset rdata", rdata, 32'd0);
      check("R1 reset irq", {31'd0, irq}, 32'd0);
    end
    // R2 / R3: run with limit 3, watch the image register each cycle
    cur_req = "R2";
    cyc(1'b1, 1'b0, 2'd0, mode_word(3, 1, 0), 1'b0);
    idle(150, 2'd3, 1'b0);
    cur_req = "R3";
    cyc(1'b1, 1'b0, 2'd0, mode_word(0, 1, 0), 1'b0);
    idle(80, 2'd3, 1'b0);
    cyc(1'b1, 1'b0, 2'd0, mode_word(9, 1, 0), 1'b0);
    idle(120, 2'd3, 1'b0);
    cyc(1'b1, 1'b0, 2'd0, mode_word(2, 1, 0), 1'b0);
    idle(100, 2'd3, 1'b0);
    // R5: rewrite limit mid-interval
    cur_req = "R5";
    cyc(1'b1, 1'b0, 2'd0, mode_word(6, 1, 0), 1'b0);
    idle(40, 2'd3, 1'b0);
    cyc(1'b1, 1'b0, 2'd0, mode_word(12, 1, 0), 1'b0);
    idle(100, 2'd3, 1'b0);
    // R4: interrupt enable
    cur_req = "R4";
    cyc(1'b1, 1'b0, 2'd0, mode_word(12, 1, 1), 1'b0);
    idle(60, 2'd1, 1'b0);
    check("R4 irq with flag and ie", {31'd0, irq}, 32'd1);
    // R6: acknowledging reads
    cur_req = "R6";
    cyc(1'b0, 1'b1, 2'd2, '0, 1'b0);
    cyc(1'b0, 1'b0, 2'd2, '0, 1'b0);
    check("R6 count cleared", {20'd0, rdata[31:20]}, 32'd0);
    check("R6 irq cleared", {31'd0, irq}, 32'd0);
    for (int k = 0; k < 12; k++) begin
      idle(37, 2'd1, 1'b0);
      cyc(1'b0, 1'b1, 2'd2, '0, 1'b0);
    end
    // R7: continuous image reads
    cur_req = "R7";
    for (int k = 0; k < 250; k++) cyc(1'b0, 1'b1, 2'd3, '0, 1'b0);
    // R10: acknowledge exactly on a wrap edge
    cur_req = "R10";
    cyc(1'b1, 1'b0, 2'd0, mode_word(1, 1, 1), 1'b0);
    hit = 0;
    for (int k = 0; k < 100 && !hit; k++) begin
      @(negedge clk);
      compare_model();
      wr_en = 0; dbg_halt = 0;
      if (m_run && m_p == 15 && m_c >= m_piv) begin
        rd_en = 1; addr = 2'd2; hit = 1;
      end else begin
        rd_en = 0; addr = 2'd3;
      end
    end
    cyc(1'b0, 1'b0, 2'd2, '0, 1'b0);
    check("R10 count is one", {20'd0, rdata[31:20]}, 32'd1);
    check("R10 irq stays", {31'd0, irq}, 32'd1);
    cyc(1'b0, 1'b1, 2'd2, '0, 1'b0);
    // R8: disable mid-interval, counter finishes then parks at zero
    cur_req = "R8";
    cyc(1'b1, 1'b0, 2'd0, mode_word(5, 1, 0), 1'b0);
    idle(50, 2'd3, 1'b0);
    cyc(1'b1, 1'b0, 2'd0, mode_word(5, 0, 0), 1'b0);
    idle(140, 2'd3, 1'b0);
    check("R8 parked at zero", {12'd0, rdata[19:0]}, 32'd0);
    idle(60, 2'd3, 1'b0);
    check("R8 still parked", {12'd0, rdata[19:0]}, 32'd0);
    cyc(1'b1, 1'b0, 2'd0, mode_word(5, 1, 0), 1'b0);
    idle(17, 2'd3, 1'b0);
    check("R8 no tick before 16 clocks", {12'd0, rdata[19:0]}, 32'd0);
    idle(50, 2'd3, 1'b0);
    cyc(1'b1, 1'b0, 2'd0, mode_word(5, 0, 0), 1'b0);
    idle(10, 2'd3, 1'b0);
    cyc(1'b1, 1'b0, 2'd0, mode_word(5, 1, 0), 1'b0);
    idle(120, 2'd3, 1'b0);
    // R9: halt freezes everything
    cur_req = "R9";
    idle(23, 2'd3, 1'b0);
    @(negedge clk); compare_model(); snap = rdata; dbg_halt = 1;
    idle(45, 2'd3, 1'b1);
    check("R9 frozen under halt", rdata, snap);
    idle(80, 2'd3, 1'b0);
    // R11: saturation of elapsed count
    cur_req = "R11";
    cyc(1'b1, 1'b0, 2'd0, mode_word(0, 1, 0), 1'b0);
    idle(4100 * 16, 2'd3, 1'b0);
    check("R11 saturated", {20'd0, rdata[31:20]}, 32'd4095);
    idle(64, 2'd3, 1'b0);
    check("R11 still saturated", {20'd0, rdata[31:20]}, 32'd4095);
    cyc(1'b0, 1'b1, 2'd2, '0, 1'b0);
    idle(4, 2'd3, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule